// File: doc/BRIEF.md
# Two-Wire Master SCL Rate Generator

This block produces the clock line for the master side of a two-wire serial bus, working from the system clock. A divider value and a two-bit prescaler code set the SCL period. The output is an open-drain style "pull SCL low" request; the pad and the bus pull-up set the high level. The block reads the SCL line back, so a slave that holds the clock low stretches the high phase instead of shortening it.

The byte engine that sits beside it asks for clocking with a run request. It can also freeze the bus with a hold request, which parks SCL low while the engine waits for service. Two single-cycle strobes tell the engine where to act. One fires in the middle of each low phase, where SDA may change. The other fires in the middle of each high phase, where SDA is sampled. Data shifting, START/STOP sequencing and slave-side timing belong to other blocks.

Top module: `scl_rate_gen`

## Requirements
- R1: With the run request held and no stretching, one SCL period (low phase plus released phase) lasts exactly 16 + 2·D·P system clocks. D is the divider value and P is the prescaler factor; both zero gives a 16-clock period.
- R2: The prescaler code selects the factor P as follows: code 0 → 1, code 1 → 4, code 2 → 16, code 3 → 64.
- R3: Without stretching or hold, the low phase lasts H = 8 + D·P clocks and the released phase also lasts H clocks.
- R4: After reset, with the enable low, SCL is released and neither strobe fires.
- R5: Counting of the high phase starts only in the cycle SCL is read back high. If the line is held low for k extra clocks after release, the released phase lasts k + H clocks.
- R6: Whenever hold is asserted, including from idle, SCL is pulled low and stays low for as long as hold stays asserted. If the low phase has already run its full count, SCL is released in the first cycle after hold drops.
- R7: The change strobe is a single-cycle pulse in the low phase, at index floor(H/2), where index 0 is the first cycle SCL is pulled low.
- R8: The sample strobe is a single-cycle pulse in the released phase, at index k + floor(H/2), where index 0 is the first released cycle and k is the number of stretched clocks.
- R9: Dropping the enable releases SCL in the next cycle and clears all counting. After re-enable, the first low phase lasts a full H clocks.
- R10: If the run request and hold are both low when a high phase ends, SCL stays released. A later run request pulls SCL low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Generator enable; low releases SCL and clears counting |
| run | input | 1 | Byte engine requests continued clocking |
| hold | input | 1 | Keeps SCL low while asserted |
| div_val | input | DIV_W | Divider value D |
| pre_code | input | PRE_W | Prescaler code selecting P = 4^code |
| scl_in | input | 1 | SCL line as read back from the bus |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| chg_tick | output | 1 | Single-cycle strobe at mid-low (data change point) |
| smp_tick | output | 1 | Single-cycle strobe at mid-high (data sample point) |

## Verification
On every cycle, the assertions check that:
- disabling releases the line;
- hold never lets SCL go high;
- the change strobe appears only while SCL is pulled low, and the sample strobe only while it is released;
- no low phase ends before its programmed length.

Exact phase lengths, strobe positions, prescaler scaling and the delay added by stretching can only be shown by the bench's sweeps, which measure them at the ports across divider and prescaler settings. The stop-and-restart behaviour of the run request also needs those scenarios.

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int DIV_W = 8,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             run,
  input  logic             hold,
  input  logic [DIV_W-1:0] div_val,
  input  logic [PRE_W-1:0] pre_code,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             chg_tick,
  output logic             smp_tick
);

  localparam int MAX_SHIFT = 2 * ((1 << PRE_W) - 1);
  localparam int CNT_W     = DIV_W + MAX_SHIFT + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_WAIT, ST_HIGH} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_len;
  logic [CNT_W-1:0] mid_pt;
  logic [CNT_W-1:0] last_pt;
  logic [PRE_W:0]   shamt;

  assign shamt    = {pre_code, 1'b0};
  assign half_len = CNT_W'(8) + (CNT_W'(div_val) << shamt);
  assign mid_pt   = half_len >> 1;
  assign last_pt  = half_len - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (!en) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (run || hold) begin
          state <= ST_LOW;
          cnt   <= '0;
        end
        ST_LOW: begin
          if (cnt >= last_pt) begin
            if (!hold) begin
              state <= ST_WAIT;
              cnt   <= '0;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_WAIT: if (scl_in) begin
          state <= ST_HIGH;
          cnt   <= CNT_W'(1);
        end
        default: begin
          if (cnt >= last_pt) begin
            state <= (run || hold) ? ST_LOW : ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign scl_drive_low = (state == ST_LOW);
  assign chg_tick      = (state == ST_LOW)  && (cnt == mid_pt);
  assign smp_tick      = (state == ST_HIGH) && (cnt == mid_pt);

  logic [CNT_W:0] low_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 low_len <= '0;
    else if (!scl_drive_low)    low_len <= '0;
    else if (~&low_len)         low_len <= low_len + 1'b1;
  end

  AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !scl_drive_low); // R9
  AST_HOLD_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hold && scl_drive_low) |=> scl_drive_low); // R6
  AST_CHG_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    chg_tick |-> scl_drive_low); // R7
  AST_SMP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    smp_tick |-> !scl_drive_low); // R8
  AST_LOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $fell(scl_drive_low)) |-> (low_len >= {1'b0, half_len})); // R3

endmodule

// File: tb/scl_rate_gen_bench.sv
module scl_rate_gen_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       en = 0, run = 0, hold = 0, stretch = 0;
  logic [7:0] div_val = 0;
  logic [1:0] pre_code = 0;
  logic       scl_low, chg, smp, scl_in;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #2 clk = ~clk;
  assign scl_in = !(scl_low || stretch);

  scl_rate_gen u_scl_rate_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .run(run), .hold(hold),
    .div_val(div_val), .pre_code(pre_code), .scl_in(scl_in),
    .scl_drive_low(scl_low), .chg_tick(chg), .smp_tick(smp));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pfac(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 16;
      default: return 64;
    endcase
  endfunction

  task automatic measure(input int d, input int code, input int k);
    int h, t, low_len, high_len, chg_at, smp_at;
    h = 8 + d * pfac(code);
    @(negedge clk); en = 0;
    @(negedge clk);
    div_val = 8'(d); pre_code = 2'(code); run = 1; en = 1;
    t = 0;
    while (!scl_low && t < 10) begin @(negedge clk); t++; end
    chk(t == 1, "R10 start latency", t, 1);
    t = 0; chg_at = -1;
    while (scl_low && t < 100000) begin
      if (chg) chg_at = t;
      t++; @(negedge clk);
    end
    low_len = t;
    t = 0; smp_at = -1;
    while (!scl_low && t < 100000) begin
      stretch = (t < k);
      if (smp) smp_at = t;
      t++; @(negedge clk);
    end
    stretch = 0;
    high_len = t;
    chk(low_len == h, "R3 low phase", low_len, h);
    chk(high_len == h + k, k > 0 ? "R5 stretched high" : "R3 high phase", high_len, h + k);
    chk(low_len + high_len == 16 + 2 * d * pfac(code) + k, "R1 period",
        low_len + high_len, 16 + 2 * d * pfac(code) + k);
    if (d > 0) chk((low_len - 8) / d == pfac(code), "R2 prescaler", (low_len - 8) / d, pfac(code));
    chk(chg_at == h / 2, "R7 change strobe", chg_at, h / 2);
    chk(smp_at == k + h / 2, "R8 sample strobe", smp_at, k + h / 2);
    en = 0; run = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int t;
    bit ok;
    repeat (3) @(negedge clk);
    chk(!scl_low && !chg && !smp, "R4 reset state", scl_low, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!scl_low && !chg && !smp, "R4 idle after reset", scl_low, 0);

    foreach (div_val[i]) ; // no-op
    for (int code = 0; code < 4; code++) begin
      measure(0, code, 0);
      measure(1, code, 0);
      measure(2, code, 0);
      measure(5, code, 0);
      measure(13, code, 0);
    end
    measure(255, 0, 0);
    measure(255, 1, 0);
    measure(0, 0, 1);
    measure(1, 1, 5);
    measure(3, 0, 20);

    // R6: hold from idle keeps SCL low, release one cycle after hold drops
    @(negedge clk); div_val = 1; pre_code = 0; run = 0; hold = 0; en = 1;
    repeat (3) @(negedge clk);
    chk(!scl_low, "R10 idle without run", scl_low, 0);
    hold = 1;
    @(negedge clk);
    chk(scl_low, "R6 hold pulls low", scl_low, 1);
    ok = 1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (!scl_low) ok = 0; end
    chk(ok, "R6 low during hold", ok, 1);
    hold = 0;
    @(negedge clk);
    chk(!scl_low, "R6 release after hold", scl_low, 0);

    // R10: run dropped, SCL stays released after the high phase
    t = 0;
    while (!scl_low && t < 40) begin @(negedge clk); t++; end
    chk(!scl_low, "R10 no restart without run", scl_low, 0);
    run = 1;
    @(negedge clk);
    chk(scl_low, "R10 restart on run", scl_low, 1);

    // R9: disable mid low phase
    repeat (3) @(negedge clk);
    en = 0;
    @(negedge clk);
    chk(!scl_low, "R9 release on disable", scl_low, 0);
    ok = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (scl_low || chg || smp) ok = 0; end
    chk(ok, "R9 quiet while disabled", ok, 1);
    en = 1;
    @(negedge clk);
    t = 0;
    while (scl_low && t < 100) begin t++; @(negedge clk); end
    chk(t == 9, "R9 full low after re-enable", t, 9);
    en = 0; run = 0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule